// File: doc/BRIEF.md
# ADC Channel Sequencer

This block runs a single 10-bit converter that is shared by two input groups of seven multiplexed analog channels each. Software sets an enable bit, a run mode, a target group, a per-group channel select and a 4-bit settle code. It then pulses a start request. For each conversion the sequencer:

- points the multiplexer at a channel;
- waits a settle time of the code multiplied by a fixed tick count;
- pulses the converter start;
- waits for the converter's busy handshake to finish;
- stores the 10-bit result in a per-channel array.

In single mode only the selected channel of the target group is converted. In group mode all seven channels are converted in ascending order. A sticky done flag and a one-cycle interrupt pulse mark the end of a run.

Results are read back combinationally. The readout group input and that group's channel select pick the stored value, so the same select field chooses both what is converted and what is read. The analog converter is outside the block and talks to it through a start pulse, a busy level and a data bus that is valid when busy falls.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, seq_busy, seq_done, done_irq and conv_start are 0, and every stored result reads as 0.
- R2: While cfg_enable is 0 a start request is ignored: no conv_start pulse occurs and seq_busy stays 0.
- R3: In single mode (cfg_single=1), a run converts only the channel named by the target group's 3-bit select and stores the result at that channel only.
- R4: In group mode (cfg_single=0), a run converts channels 0 to 6 of the target group in ascending order, exactly one conversion each, and stores every result.
- R5: With settle code D and tick count T, the first conv_start of a run is high D*T+1 cycles after the clock edge that accepts the start. Every later conv_start follows its multiplexer change by at least D*T cycles.
- R6: conv_start is a single-cycle pulse, and the multiplexer outputs do not change in the cycle it is high.
- R7: When the last result of a run is stored, seq_done rises and done_irq is high for exactly one cycle. seq_done stays high until the next accepted start clears it.
- R8: A start request while a run is in progress is ignored, and the run continues unchanged on its latched group.
- R9: rd_data returns the stored result for group rd_group at the channel given by that group's select field. A select value of 7 reads 0.
- R10: A single-mode start whose channel select is 7 is ignored and produces no conversion.
- R11: Clearing cfg_enable during a run aborts it. seq_busy is 0 after the next clock edge and no done or interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Converter enable; low blocks and aborts runs |
| cfg_single | input | 1 | 1 = convert the selected channel only, 0 = whole group |
| cfg_group | input | 1 | Target group for the next run |
| cfg_chan_sel | input | 6 | Per-group 3-bit channel select, group g at bits [3g+2:3g] |
| cfg_delay | input | 4 | Settle code, multiplied by the tick count |
| start_req | input | 1 | One-cycle run request |
| mux_group | output | 1 | Multiplexer group select |
| mux_chan | output | 3 | Multiplexer channel select |
| conv_start | output | 1 | Converter start pulse |
| conv_busy | input | 1 | Converter busy level |
| conv_data | input | 10 | Converter result, valid when busy falls |
| rd_group | input | 1 | Group whose selected result is read |
| rd_data | output | 10 | Stored result for the read selection |
| seq_busy | output | 1 | Run in progress |
| seq_done | output | 1 | Sticky end-of-run flag |
| done_irq | output | 1 | One-cycle end-of-run pulse |

## Verification
The first converter start is due D*T+1 edges after the accepting edge. The bench counts edges from that edge and samples conv_start on each following falling edge, so the count is exact for every settle code in the sweep. A conversion result lands in the array one edge after the converter drops busy, and done_irq is high in the cycle after that write. The bench therefore waits for seq_busy to fall and then one more cycle before it compares interrupt counts and reads results back. An abort is checked on the first falling edge after enable is cleared.

// File: rtl/adc_seq_pkg.sv
// Package: shared types for the ADC channel sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_seq_pkg;

    // Sequencer control states
    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_SETTLE    = 3'd1,
        S_LAUNCH    = 3'd2,
        S_WAIT_BUSY = 3'd3,
        S_WAIT_DONE = 3'd4
    } seq_state_e;

endpackage

// File: rtl/adc_seq_settle.sv
// Module: adc_seq_settle
// Settle timer. It loads code*TICK_DIV on load and counts down to zero.
// expired is high while the count is zero and no load is pending.
// Assumes: load is a one-cycle request from the sequencer FSM.
module adc_seq_settle #(
    parameter int DLY_W    = 4,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] delay_code,
    output logic             expired
);
    localparam int MAX_CNT = ((1 << DLY_W) - 1) * TICK_DIV;
    localparam int CNT_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT + 1) : 1;

    logic [CNT_W-1:0] cnt;

    // Load the scaled settle time, or count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(delay_code) * CNT_W'(TICK_DIV);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Settle window has elapsed
    assign expired = (cnt == '0) && !load;

endmodule

// File: rtl/adc_seq_store.sv
// Module: adc_seq_store
// Per-channel result array with one write port and a combinational read.
// A read of a channel code outside 0..CH_PER_GRP-1 returns zero.
// Assumes: wr_grp/wr_ch are always in range when wr_en is high.
module adc_seq_store #(
    parameter int RES_W      = 10,
    parameter int NUM_GRP    = 2,
    parameter int CH_PER_GRP = 7,
    parameter int GRP_W      = 1,
    parameter int CH_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [RES_W-1:0] wr_data,
    input  logic [GRP_W-1:0] rd_grp,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [RES_W-1:0] rd_data
);
    logic [RES_W-1:0] mem [NUM_GRP][CH_PER_GRP];

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        for (genvar c = 0; c < CH_PER_GRP; c++) begin : g_ch
            // Capture the converter result addressed to this slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[g][c] <= '0;
                end else if (wr_en && wr_grp == GRP_W'(g) && wr_ch == CH_W'(c)) begin
                    mem[g][c] <= wr_data;
                end
            end
        end
    end

    // Select the stored result for the requested group and channel
    always_comb begin
        rd_data = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            for (int c = 0; c < CH_PER_GRP; c++) begin
                if (rd_grp == GRP_W'(g) && rd_ch == CH_W'(c)) begin
                    rd_data = mem[g][c];
                end
            end
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
// Module: adc_seq_fsm
// Run sequencer. It accepts a start, walks the channels of a group (or
// one channel), settles, launches and waits out each conversion, then
// raises done and a one-cycle interrupt.
// Assumes: the converter raises busy after a start pulse and lowers it
// with valid data. Clearing cfg_enable aborts any run.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NUM_GRP    = 2,
    parameter int CH_PER_GRP = 7,
    parameter int GRP_W      = 1,
    parameter int CH_W       = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_enable,
    input  logic                    cfg_single,
    input  logic [GRP_W-1:0]        cfg_group,
    input  logic [NUM_GRP*CH_W-1:0] cfg_chan_sel,
    input  logic                    start_req,
    input  logic                    conv_busy,
    input  logic                    settle_expired,
    output logic                    settle_load,
    output logic                    conv_start,
    output logic                    wr_en,
    output logic [GRP_W-1:0]        cur_grp,
    output logic [CH_W-1:0]         cur_ch,
    output logic                    seq_busy,
    output logic                    seq_done,
    output logic                    done_irq
);
    seq_state_e state;
    logic       run_single;
    logic [CH_W-1:0] req_ch;
    logic       grp_ok;
    logic       accept;
    logic       conv_end;
    logic       last_ch;

    // Decode the request: the channel it names and whether it is legal
    always_comb begin
        req_ch = cfg_chan_sel[int'(cfg_group)*CH_W +: CH_W];
        grp_ok = int'(cfg_group) < NUM_GRP;
        accept = (state == S_IDLE) && cfg_enable && start_req && grp_ok &&
                 (!cfg_single || int'(req_ch) < CH_PER_GRP);
    end

    // End-of-conversion and last-channel detection
    always_comb begin
        conv_end = cfg_enable && (state == S_WAIT_DONE) && !conv_busy;
        last_ch  = run_single || (cur_ch == CH_W'(CH_PER_GRP - 1));
    end

    // Main state register with the run context and completion flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            cur_grp    <= '0;
            cur_ch     <= '0;
            run_single <= 1'b0;
            seq_done   <= 1'b0;
            done_irq   <= 1'b0;
        end else begin
            done_irq <= 1'b0;
            if (!cfg_enable) begin
                state <= S_IDLE;
            end else begin
                unique case (state)
                    S_IDLE: begin
                        if (accept) begin
                            state      <= S_SETTLE;
                            cur_grp    <= cfg_group;
                            cur_ch     <= cfg_single ? req_ch : '0;
                            run_single <= cfg_single;
                            seq_done   <= 1'b0;
                        end
                    end
                    S_SETTLE: begin
                        if (settle_expired) state <= S_LAUNCH;
                    end
                    S_LAUNCH: begin
                        state <= S_WAIT_BUSY;
                    end
                    S_WAIT_BUSY: begin
                        if (conv_busy) state <= S_WAIT_DONE;
                    end
                    S_WAIT_DONE: begin
                        if (!conv_busy) begin
                            if (last_ch) begin
                                state    <= S_IDLE;
                                seq_done <= 1'b1;
                                done_irq <= 1'b1;
                            end else begin
                                state  <= S_SETTLE;
                                cur_ch <= cur_ch + CH_W'(1);
                            end
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // Strobes toward the settle timer, converter and result array
    always_comb begin
        settle_load = accept || (conv_end && !last_ch);
        conv_start  = (state == S_LAUNCH);
        wr_en       = conv_end;
        seq_busy    = (state != S_IDLE);
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: adc_seq_ctrl (top)
// ADC channel sequencer. It ties the run FSM, the settle timer and the
// per-channel result array together and drives the multiplexer and the
// converter handshake.
// Assumes: one converter shared by NUM_GRP groups of CH_PER_GRP inputs.
// cfg_delay stays stable during a run.
module adc_seq_ctrl #(
    parameter int RES_W      = 10,
    parameter int NUM_GRP    = 2,
    parameter int CH_PER_GRP = 7,
    parameter int DLY_W      = 4,
    parameter int TICK_DIV   = 4,
    localparam int GRP_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int CH_W      = $clog2(CH_PER_GRP + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_enable,
    input  logic                    cfg_single,
    input  logic [GRP_W-1:0]        cfg_group,
    input  logic [NUM_GRP*CH_W-1:0] cfg_chan_sel,
    input  logic [DLY_W-1:0]        cfg_delay,
    input  logic                    start_req,
    output logic [GRP_W-1:0]        mux_group,
    output logic [CH_W-1:0]         mux_chan,
    output logic                    conv_start,
    input  logic                    conv_busy,
    input  logic [RES_W-1:0]        conv_data,
    input  logic [GRP_W-1:0]        rd_group,
    output logic [RES_W-1:0]        rd_data,
    output logic                    seq_busy,
    output logic                    seq_done,
    output logic                    done_irq
);
    logic            settle_load;
    logic            settle_expired;
    logic            wr_en;
    logic [CH_W-1:0] rd_ch;

    adc_seq_fsm #(
        .NUM_GRP(NUM_GRP), .CH_PER_GRP(CH_PER_GRP), .GRP_W(GRP_W), .CH_W(CH_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cfg_enable(cfg_enable), .cfg_single(cfg_single),
        .cfg_group(cfg_group), .cfg_chan_sel(cfg_chan_sel),
        .start_req(start_req), .conv_busy(conv_busy),
        .settle_expired(settle_expired), .settle_load(settle_load),
        .conv_start(conv_start), .wr_en(wr_en),
        .cur_grp(mux_group), .cur_ch(mux_chan),
        .seq_busy(seq_busy), .seq_done(seq_done), .done_irq(done_irq)
    );

    adc_seq_settle #(.DLY_W(DLY_W), .TICK_DIV(TICK_DIV)) u_settle (
        .clk(clk), .rst_n(rst_n), .load(settle_load),
        .delay_code(cfg_delay), .expired(settle_expired)
    );

    // Readout channel comes from the select field of the readout group
    assign rd_ch = cfg_chan_sel[int'(rd_group)*CH_W +: CH_W];

    adc_seq_store #(
        .RES_W(RES_W), .NUM_GRP(NUM_GRP), .CH_PER_GRP(CH_PER_GRP),
        .GRP_W(GRP_W), .CH_W(CH_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_grp(mux_group), .wr_ch(mux_chan), .wr_data(conv_data),
        .rd_grp(rd_group), .rd_ch(rd_ch), .rd_data(rd_data)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Module: adc_seq_ctrl_chk
// Protocol checker for the sequencer, attached to every adc_seq_ctrl
// instance by the bind at the bottom of this file.
// Assumes: cfg_delay is stable during a run.
module adc_seq_ctrl_chk #(
    parameter int CH_PER_GRP = 7,
    parameter int DLY_W      = 4,
    parameter int TICK_DIV   = 4,
    parameter int CH_W       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic [DLY_W-1:0] cfg_delay,
    input logic             conv_start,
    input logic [CH_W-1:0]  mux_chan,
    input logic             seq_busy,
    input logic             seq_done,
    input logic             done_irq
);
    logic [15:0] gap;

    // Cycles of a run since the previous launch (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n || !seq_busy || conv_start) gap <= '0;
        else if (gap != 16'hFFFF)               gap <= gap + 16'd1;
    end

    p_disabled_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !seq_busy);
    p_abort_no_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !done_irq);
    p_chan_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> (mux_chan < CH_W'(CH_PER_GRP)));
    p_settle_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (gap >= 16'(cfg_delay) * 16'(TICK_DIV)));
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    p_mux_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> $stable(mux_chan));
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);
    p_irq_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> seq_done);
    p_done_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> !seq_done);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .CH_PER_GRP(CH_PER_GRP), .DLY_W(DLY_W), .TICK_DIV(TICK_DIV), .CH_W(CH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_delay(cfg_delay),
    .conv_start(conv_start), .mux_chan(mux_chan), .seq_busy(seq_busy),
    .seq_done(seq_done), .done_irq(done_irq)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
    localparam int TICK = 4;
    localparam int LAT  = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_enable, cfg_single, cfg_group, start_req, rd_group;
    logic [5:0] cfg_chan_sel;
    logic [3:0] cfg_delay;
    logic       mux_group, conv_start, conv_busy, seq_busy, seq_done, done_irq;
    logic [2:0] mux_chan;
    logic [9:0] conv_data, rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_single(cfg_single),
        .cfg_group(cfg_group), .cfg_chan_sel(cfg_chan_sel), .cfg_delay(cfg_delay),
        .start_req(start_req), .mux_group(mux_group), .mux_chan(mux_chan),
        .conv_start(conv_start), .conv_busy(conv_busy), .conv_data(conv_data),
        .rd_group(rd_group), .rd_data(rd_data), .seq_busy(seq_busy),
        .seq_done(seq_done), .done_irq(done_irq)
    );

    // Converter model: busy for LAT cycles, a fresh value per conversion
    logic       m_busy = 1'b0;
    int         m_cnt = 0;
    int         m_slot = 0;
    logic [9:0] m_data = '0;
    int         conv_total = 0;
    int         irq_total = 0;
    int         hist_g[16];
    int         hist_c[16];
    int         exp_mem[14];

    assign conv_busy = m_busy;
    assign conv_data = m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_cnt  <= 0;
        end else if (m_busy) begin
            if (m_cnt == 1) begin
                m_busy <= 1'b0;
                exp_mem[m_slot] <= int'(m_data);
            end else begin
                m_cnt <= m_cnt - 1;
            end
        end else if (conv_start) begin
            m_busy <= 1'b1;
            m_cnt  <= LAT;
            m_slot <= int'(mux_group) * 7 + int'(mux_chan);
            m_data <= 10'((conv_total * 97 + int'(mux_group) * 131 + int'(mux_chan) * 17 + 5) % 1024);
            hist_g[conv_total % 16] <= int'(mux_group);
            hist_c[conv_total % 16] <= int'(mux_chan);
            conv_total <= conv_total + 1;
        end
        if (rst_n && done_irq) irq_total <= irq_total + 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_slot(input int g, input int ch, output int val);
        cfg_chan_sel[g*3 +: 3] = 3'(ch);
        rd_group = g[0];
        #1;
        val = int'(rd_data);
    endtask

    // One run: configure, pulse start, measure first-launch latency, wait end
    task automatic do_run(input int g, input int single, input int sel,
                          input int dly, input int poke, output int lat);
        int gd;
        cfg_group = g[0];
        cfg_single = single[0];
        cfg_chan_sel[g*3 +: 3] = 3'(sel);
        cfg_delay = 4'(dly);
        @(negedge clk) start_req = 1'b1;
        @(posedge clk);
        @(negedge clk) start_req = 1'b0;
        lat = 0;
        while (!conv_start && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        if (poke != 0) begin
            start_req = 1'b1;
            cfg_group = ~g[0];
            @(negedge clk);
            start_req = 1'b0;
            cfg_group = g[0];
        end
        gd = 0;
        while (seq_busy && gd < 3000) begin
            @(negedge clk);
            gd++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int lat, base, v, irq0;
        for (int i = 0; i < 14; i++) exp_mem[i] = 0;
        rst_n = 1'b0; cfg_enable = 1'b0; cfg_single = 1'b0; cfg_group = 1'b0;
        start_req = 1'b0; rd_group = 1'b0; cfg_chan_sel = '0; cfg_delay = '0;
        wait_cycles(4);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "seq_busy", int'(seq_busy), 0);
        chk("R1", "seq_done", int'(seq_done), 0);
        chk("R1", "conv_start", int'(conv_start), 0);
        for (int g = 0; g < 2; g++)
            for (int c = 0; c < 7; c++) begin
                read_slot(g, c, v);
                chk("R1", "reset result", v, 0);
            end

        // R2: start ignored while disabled
        base = conv_total;
        do_run(0, 1, 2, 1, 0, lat);
        wait_cycles(20);
        chk("R2", "conversions while disabled", conv_total - base, 0);
        chk("R2", "busy while disabled", int'(seq_busy), 0);

        // R10: single mode with select 7 ignored
        cfg_enable = 1'b1;
        base = conv_total;
        do_run(1, 1, 7, 0, 0, lat);
        wait_cycles(20);
        chk("R10", "conversions for select 7", conv_total - base, 0);
        chk("R10", "busy for select 7", int'(seq_busy), 0);

        // R3/R5/R7/R9: single-mode sweep over every channel and many codes
        for (int g = 0; g < 2; g++)
            for (int c = 0; c < 7; c++) begin
                int dly = (g * 7 + c * 3) % 16;
                base = conv_total;
                irq0 = irq_total;
                do_run(g, 1, c, dly, 0, lat);
                chk("R5", "first launch latency", lat, dly * TICK + 1);
                chk("R3", "one conversion", conv_total - base, 1);
                chk("R3", "converted group", hist_g[base % 16], g);
                chk("R3", "converted channel", hist_c[base % 16], c);
                chk("R7", "done flag", int'(seq_done), 1);
                chk("R7", "one interrupt", irq_total - irq0, 1);
                read_slot(g, c, v);
                chk("R9", "readback", v, exp_mem[g * 7 + c]);
                read_slot(g, (c + 1) % 7, v);
                chk("R3", "neighbour untouched", v, exp_mem[g * 7 + (c + 1) % 7]);
                cfg_chan_sel[g*3 +: 3] = 3'(c);
            end

        // R4/R8: group runs, second one with a start poked in mid-run
        for (int g = 0; g < 2; g++) begin
            base = conv_total;
            irq0 = irq_total;
            do_run(g, 0, 0, 2 + g, g, lat);
            chk("R4", "conversions per group", conv_total - base, 7);
            chk("R7", "one interrupt per group run", irq_total - irq0, 1);
            for (int k = 0; k < 7; k++) begin
                chk("R4", "order channel", hist_c[(base + k) % 16], k);
                chk(g == 1 ? "R8" : "R4", "order group", hist_g[(base + k) % 16], g);
            end
            for (int c = 0; c < 7; c++) begin
                read_slot(g, c, v);
                chk("R9", "group readback", v, exp_mem[g * 7 + c]);
            end
        end
        wait_cycles(10);
        chk("R8", "no extra run after poke", int'(seq_busy), 0);
        chk("R7", "done held", int'(seq_done), 1);

        // R9: select 7 reads zero
        read_slot(0, 7, v);
        chk("R9", "select 7 readback", v, 0);

        // R11: abort by clearing enable; R7: start clears done
        irq0 = irq_total;
        base = conv_total;
        cfg_group = 1'b0; cfg_single = 1'b0; cfg_delay = 4'd3;
        @(negedge clk) start_req = 1'b1;
        @(posedge clk);
        @(negedge clk) start_req = 1'b0;
        chk("R7", "done cleared by start", int'(seq_done), 0);
        for (int i = 0; i < 2000 && conv_total - base < 2; i++) @(negedge clk);
        cfg_enable = 1'b0;
        @(negedge clk);
        chk("R11", "busy after abort", int'(seq_busy), 0);
        chk("R11", "done after abort", int'(seq_done), 0);
        wait_cycles(10);
        chk("R11", "no interrupt on abort", irq_total - irq0, 0);
        cfg_enable = 1'b1;
        base = conv_total;
        do_run(0, 0, 0, 0, 0, lat);
        chk("R4", "resync conversions", conv_total - base, 7);
        for (int c = 0; c < 7; c++) begin
            read_slot(0, c, v);
            chk("R9", "resync readback", v, exp_mem[c]);
        end

        summary();
        $finish;
    end
endmodule